// File: doc/BRIEF.md
# Dithered LED Dimming Generator

This block produces the gate signal for an LED current sink from a 24 MHz clock. Software writes a 10-bit duty code through a small register port. The low byte is written first, then the two upper bits. The upper eight bits of the code set how many of the 256 ticks in each PWM period are high. The two lowest bits are spread over a cycle of four periods: that many periods in the cycle get one extra high tick. Over four periods this gives an effective resolution of 1/1024.

A fixed 10-bit floor comes in on an input. A code written below the floor stays readable as written, but the generator runs at the floor instead. The new code is double-buffered. It goes live when the upper bits have been written and the running four-period cycle has ended. While the generator is idle, it goes live at once. A 2-bit rate select divides the clock by 4, 8, 16 or 32 to make the tick, which gives PWM periods near 23.4, 11.7, 5.9 and 2.9 kHz. The external LED enable pin is synchronised by two flops. While it is low the gate is held off and the counters are held at zero, so each new enable starts a fresh cycle at tick 0 of phase 0.

Top module: `led_dim_pwm`

## Requirements
- R1: After reset, the duty readback is 0x000, the rate readback is 3 and the gate is low.
- R2: A write with address 0 loads data[7:0] into duty bits [7:0]. Address 1 loads data[1:0] into duty bits [9:8]. Address 2 loads data[1:0] into the rate select. The duty readback shows the written code at once, even when that code is below the floor, and changes on no other cycle.
- R3: Each period is 256 ticks. Period p of the four-period cycle (p = 0..3) is high for duty[9:2] ticks, plus one tick when p < duty[1:0]. The high time summed over one cycle is duty × divider clocks.
- R4: The extra dither ticks fall in separate periods. Code 0x001 gives one high pulse per cycle and code 0x002 gives two.
- R5: The tick divider is 4 << rate select. A full cycle lasts 1024 × divider clocks.
- R6: Code 0x3FF leaves the gate low for exactly one tick per cycle, in the last tick of phase 3.
- R7: A code below the floor runs at the floor. A code equal to or above the floor runs as written.
- R8: A write to address 0 alone never changes the running duty. After a write to address 1, the new duty starts at the first tick after the running cycle ends. The cycle in progress completes with the old duty.
- R9: Two clocks after the LED enable pin goes low, the gate is low, and it stays low while the pin is low.
- R10: Two clocks after the LED enable pin rises, the cycle restarts at tick 0 of phase 0, so the gate is high at once for any nonzero coarse duty. A code committed while the pin is low is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 24 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 duty low, 1 duty high, 2 rate select |
| wr_data_i | input | 8 | Write data |
| floor_i | input | 10 | Minimum duty code |
| led_en_i | input | 1 | Asynchronous LED enable pin |
| duty_rd_o | output | 10 | Duty code as written |
| rate_rd_o | output | 2 | Rate select as written |
| gate_o | output | 1 | Current sink gate |

## Verification
A wrong tick or phase count changes the total high time within one four-period window. It shows as a wrong count of high clocks, or of pulses, in a window of 1024 × divider clocks, which is at most one cycle. A wrong commit point or a wrong clamp decision changes the cycle that follows the write. Measuring the cycle that holds the write and the cycle after it, both aligned to a restart of the enable pin, exposes the error within 8192 clocks. A broken synchroniser or hold-off shows up as a gate level two clocks after an edge of the pin.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned TICK_W   = 8;   // ticks per period = 2**TICK_W
  localparam int unsigned DITH_W   = 2;   // periods per cycle = 2**DITH_W
  localparam int unsigned DUTY_W   = TICK_W + DITH_W;
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned DIV_LOG0 = 2;   // smallest divider = 2**DIV_LOG0

  typedef enum logic [1:0] {
    ADDR_DUTY_LO = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_RATE    = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/led_dim_sync.sv
module led_dim_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/led_dim_regs.sv
module led_dim_regs
  import led_dim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [DUTY_W-1:0] floor_i,
  input  logic              idle_i,
  input  logic              cycle_end_i,
  output logic [DUTY_W-1:0] duty_rd_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [DUTY_W-1:0] act_duty_o
);
  localparam int unsigned HI_W = DUTY_W - BYTE_W;

  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              pend_q, pend_d;
  logic              commit;

  assign commit = pend_q && (idle_i || cycle_end_i);

  always_comb begin
    duty_d = duty_q;
    act_d  = act_q;
    rate_d = rate_q;
    pend_d = pend_q;
    if (commit) begin
      act_d  = (duty_q < floor_i) ? floor_i : duty_q;
      pend_d = 1'b0;
    end
    if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        ADDR_DUTY_LO: duty_d[BYTE_W-1:0] = wr_data_i;
        ADDR_DUTY_HI: begin
          duty_d[DUTY_W-1:BYTE_W] = wr_data_i[HI_W-1:0];
          pend_d = 1'b1;
        end
        ADDR_RATE:    rate_d = wr_data_i[RATE_W-1:0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      act_q  <= '0;
      rate_q <= '1;
      pend_q <= 1'b0;
    end else begin
      duty_q <= duty_d;
      act_q  <= act_d;
      rate_q <= rate_d;
      pend_q <= pend_d;
    end
  end

  assign duty_rd_o  = duty_q;
  assign rate_o     = rate_q;
  assign act_duty_o = act_q;
endmodule

// File: rtl/led_dim_prescale.sv
module led_dim_prescale
  import led_dim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int unsigned PS_W = DIV_LOG0 + (1 << RATE_W) - 1;

  logic [PS_W-1:0] cnt_q, cnt_d;
  logic [PS_W-1:0] limit;

  assign limit  = PS_W'((32'd1 << (DIV_LOG0 + rate_i)) - 32'd1);
  assign tick_o = run_i && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/led_dim_core.sv
module led_dim_core
  import led_dim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] act_duty_i,
  output logic              gate_o,
  output logic              last_slot_o,
  output logic              cycle_end_o
);
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [DITH_W-1:0] ph_q, ph_d;
  logic [TICK_W-1:0] coarse;
  logic [DITH_W-1:0] dith;
  logic [TICK_W:0]   high_len;

  assign coarse   = act_duty_i[DUTY_W-1:DITH_W];
  assign dith     = act_duty_i[DITH_W-1:0];
  assign high_len = {1'b0, coarse} + {{TICK_W{1'b0}}, (ph_q < dith)};

  assign gate_o      = run_i && ({1'b0, tick_q} < high_len);
  assign last_slot_o = (&tick_q) && (&ph_q);
  assign cycle_end_o = run_i && tick_i && last_slot_o;

  always_comb begin
    tick_d = tick_q;
    ph_d   = ph_q;
    if (!run_i) begin
      tick_d = '0;
      ph_d   = '0;
    end else if (tick_i) begin
      tick_d = tick_q + 1'b1;
      if (&tick_q) ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      ph_q   <= '0;
    end else begin
      tick_q <= tick_d;
      ph_q   <= ph_d;
    end
  end
endmodule

// File: rtl/led_dim_pwm.sv
module led_dim_pwm
  import led_dim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [DUTY_W-1:0] floor_i,
  input  logic              led_en_i,
  output logic [DUTY_W-1:0] duty_rd_o,
  output logic [RATE_W-1:0] rate_rd_o,
  output logic              gate_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic              led_sync;
  logic              tick;
  logic              cycle_end;
  logic              last_slot;
  logic [DUTY_W-1:0] act_duty;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  led_dim_sync #(.STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (led_en_i),
    .sync_o  (led_sync)
  );

  led_dim_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .floor_i     (floor_i),
    .idle_i      (!led_sync),
    .cycle_end_i (cycle_end),
    .duty_rd_o   (duty_rd_o),
    .rate_o      (rate_rd_o),
    .act_duty_o  (act_duty)
  );

  led_dim_prescale i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (led_sync),
    .rate_i (rate_rd_o),
    .tick_o (tick)
  );

  led_dim_core i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (led_sync),
    .tick_i      (tick),
    .act_duty_i  (act_duty),
    .gate_o      (gate_o),
    .last_slot_o (last_slot),
    .cycle_end_o (cycle_end)
  );
endmodule

// File: rtl/led_dim_chk.sv
module led_dim_chk
  import led_dim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              led_sync,
  input logic              gate,
  input logic              wr_en,
  input logic [DUTY_W-1:0] duty_rd,
  input logic [DUTY_W-1:0] act_duty,
  input logic [DUTY_W-1:0] floor_v,
  input logic              cycle_end,
  input logic              last_slot
);
  // R9
  led_off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !led_sync |-> !gate);

  // R2
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(duty_rd));

  // R8
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_sync && $past(led_sync) && !$stable(act_duty)) |-> $past(cycle_end));

  // R7
  clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_duty) |-> (act_duty >= $past(floor_v)));

  // R6
  final_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_sync && last_slot) |-> !gate);
endmodule

bind led_dim_pwm led_dim_chk i_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .led_sync  (led_sync),
  .gate      (gate_o),
  .wr_en     (wr_en_i),
  .duty_rd   (duty_rd_o),
  .act_duty  (act_duty),
  .floor_v   (floor_i),
  .cycle_end (cycle_end),
  .last_slot (last_slot)
);

// File: tb/test_led_dim_pwm.sv
module test_led_dim_pwm;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [9:0] floor_v = 10'd0;
  logic       led_en = 1'b0;
  logic [9:0] duty_rd;
  logic [1:0] rate_rd;
  logic       gate;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_dim_pwm i_led_dim_pwm (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .floor_i   (floor_v),
    .led_en_i  (led_en),
    .duty_rd_o (duty_rd),
    .rate_rd_o (rate_rd),
    .gate_o    (gate)
  );

  // {duty[9:0], floor[9:0], rate[1:0], expected high clocks per cycle}
  localparam int NVEC = 8;
  localparam logic [53:0] VEC [NVEC] = '{
    {10'h000, 10'h000, 2'd0, 32'd0},     // R3 zero code
    {10'h200, 10'h000, 2'd0, 32'd2048},  // R3 half
    {10'h155, 10'h000, 2'd0, 32'd1364},  // R3 dither 1
    {10'h3FF, 10'h000, 2'd0, 32'd4092},  // R6 top code
    {10'h010, 10'h040, 2'd0, 32'd256},   // R7 clamped
    {10'h080, 10'h080, 2'd0, 32'd512},   // R7 equal to floor
    {10'h0C3, 10'h000, 2'd1, 32'd1560},  // R5 divider 8
    {10'h101, 10'h000, 2'd3, 32'd8224}   // R5 divider 32
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int n, output int hi, output int rs);
    logic prev;
    hi = 0; rs = 0; prev = gate;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) hi++;
      if (gate && !prev) rs++;
      prev = gate;
    end
  endtask

  task automatic led_off_load(input logic [9:0] d);
    @(negedge clk);
    led_en = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd0, d[7:0]);
    wr(2'd1, {6'd0, d[9:8]});
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi, rs, hi0, hi1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 duty readback", duty_rd, 10'h000);
    check("R1 rate readback", rate_rd, 3);
    check("R1 gate", gate, 0);

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] d;
      logic [9:0] f;
      logic [1:0] s;
      int         exp_hi;
      d = VEC[v][53:44]; f = VEC[v][43:34]; s = VEC[v][33:32];
      exp_hi = int'(VEC[v][31:0]);
      @(negedge clk);
      led_en = 1'b0;
      floor_v = f;
      repeat (4) @(negedge clk);
      wr(2'd2, {6'd0, s});
      wr(2'd0, d[7:0]);
      wr(2'd1, {6'd0, d[9:8]});
      check("R2 duty readback", duty_rd, d);
      check("R2 rate readback", rate_rd, s);
      led_en = 1'b1;
      repeat (8) @(negedge clk);
      measure(1024 * (4 << s), hi, rs);
      check($sformatf("R3/R5/R6/R7 high clocks vec %0d", v), hi, exp_hi);
    end
    floor_v = 10'h000;
    wr(2'd2, 8'd0);

    // R4 dither pulses
    led_off_load(10'h001);
    led_en = 1'b1;
    repeat (8) @(negedge clk);
    measure(4096, hi, rs);
    check("R4 pulses for code 1", rs, 1);
    check("R4 high clocks for code 1", hi, 4);
    led_off_load(10'h002);
    led_en = 1'b1;
    repeat (8) @(negedge clk);
    measure(4096, hi, rs);
    check("R4 pulses for code 2", rs, 2);

    // R9 gate held off while pin low
    led_off_load(10'h200);
    measure(200, hi, rs);
    check("R9 gate while pin low", hi, 0);
    led_en = 1'b1;
    repeat (20) @(negedge clk);
    led_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 gate two clocks after fall", gate, 0);

    // R10 restart and R8 deferred commit
    led_off_load(10'h080);
    led_en = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R10 gate high at restart", gate, 1);
    hi0 = gate ? 1 : 0;
    for (int i = 1; i < 4096; i++) begin
      if (i == 100) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h40; end
      if (i == 101) begin wr_addr = 2'd1; wr_data = 8'h03; end
      if (i == 102) wr_en = 1'b0;
      @(negedge clk);
      if (gate) hi0++;
      if (i == 102) check("R2 readback after both bytes", duty_rd, 10'h340);
    end
    check("R8 running cycle keeps old duty", hi0, 512);
    measure(4096, hi1, rs);
    check("R8 next cycle uses new duty", hi1, 3328);
    wr(2'd0, 8'h00);
    check("R2 readback after low byte", duty_rd, 10'h300);
    repeat (8200) @(negedge clk);
    measure(4096, hi, rs);
    check("R8 low byte alone has no effect", hi, 3328);
    wr(2'd1, 8'h03);
    repeat (8200) @(negedge clk);
    measure(4096, hi, rs);
    check("R8 high byte commits", hi, 3072);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule